// File: doc/BRIEF.md
# Real-Time Clock Timekeeper

This block keeps wall-clock time for a larger chip. A slow reference strobe (one system-clock-wide pulse per reference period, nominally 32768 per second) is divided down by a programmable ratio to make a tick. Each tick advances a 32-bit free-running seconds-fraction counter, which software reads and loads over a simple single-cycle register bus.

Two alarm compare registers watch the counter. When the counter steps onto an alarm value while that alarm is armed, an event flag sets. A periodic-tick flag sets on every tick. Each flag has its own enable, and the interrupt line is high while any flag is set with its enable. Flags are cleared by writing one to them. A scratch register keeps a software-owned word, such as the count of counter wraps, across the block's lifetime. A clock-select field must hold the reference code before the divider runs.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, every register reads 0 (counter, both alarms, status, divider, clock select, scratch) and `irq` is low.
- R2: Register byte offsets are: counter 0x00, alarm0 0x04, status 0x08, divider 0x0C, alarm1 0x18, clock select 0x1C, scratch 0x40. The scratch register returns the last value written and nothing else changes it; any other offset reads 0.
- R3: While clock select (bits 1:0 at 0x1C) holds 3, a tick occurs once every 2×(D+1) reference pulses, D being the divider value; with D = 1023 the counter advances 16 times per 32768 pulses. With any other clock select value, pulses have no effect. A write to the counter or the divider restarts the pulse count at 0.
- R4: Each tick adds 1 to the counter, and 0xFFFFFFFF steps to 0.
- R5: A counter write loads the written value; if a tick falls in the same cycle, the write wins and the tick is dropped.
- R6: Status bit 0 (alarm0 event) sets on the tick that steps the counter onto the alarm0 value, but only while status bit 2 (alarm0 enable) is 1.
- R7: Status bit 4 (alarm1 event) sets on the tick that steps the counter onto the alarm1 value, but only while status bit 6 (alarm1 enable) is 1.
- R8: Status bit 1 (tick event) sets on every tick, whatever its enable, status bit 3.
- R9: Writing 1 to status bit 0, 1 or 4 clears that event; writing 0 leaves it. Bits 2, 3 and 6 take the written value. An event that fires in the same cycle as its clear stays set.
- R10: `irq` is high exactly while (bit0 and bit2) or (bit1 and bit3) or (bit4 and bit6) of status is true.
- R11: A read request (`bus_sel` high, `bus_wr` low) captures the addressed register into `bus_rdata` at the next clock edge; `bus_rdata` then holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
The bench aims at the divider boundary: one pulse short of a full period must leave the counter unchanged, so a divider off by one pulse (dividing by 2D+1 or 2D+3) shows up at once, as does a divider that runs with a reserved clock select. It loads 0xFFFFFFFF to catch a counter that saturates or spills, and collides a counter write with a tick to catch a design that lets the tick add one to the loaded value. For the flags it checks that an alarm does not fire while disarmed, that writing 0 to an event bit does not clear it (a plain-write status would drop the flag), and that a pending tick event without its enable keeps the interrupt low.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets (software visible)
  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_ALARM0 = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h08;
  localparam logic [7:0] OFF_DIVIDE = 8'h0C;
  localparam logic [7:0] OFF_ALARM1 = 8'h18;
  localparam logic [7:0] OFF_CLKSEL = 8'h1C;
  localparam logic [7:0] OFF_SCRTCH = 8'h40;

  // Clock select code that lets the divider run
  localparam logic [1:0] CLKSEL_REF = 2'b11;

  // Status word bit positions
  localparam int ST_EV_ALM0 = 0;
  localparam int ST_EV_TICK = 1;
  localparam int ST_EN_ALM0 = 2;
  localparam int ST_EN_TICK = 3;
  localparam int ST_EV_ALM1 = 4;
  localparam int ST_EN_ALM1 = 6;

  // Internal event slot order used by the status block
  localparam int SLOT_ALM0 = 0;
  localparam int SLOT_TICK = 1;
  localparam int SLOT_ALM1 = 2;
  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_pulse,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int PRE_W = DIV_W + 1;

  // Last phase index of a period of 2*(div+1) pulses
  function automatic logic [PRE_W-1:0] period_last(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [PRE_W-1:0] phase_q;
  logic             at_last;

  assign at_last = (phase_q == period_last(div_val));
  assign tick    = run && ref_pulse && at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase_q <= '0;
    else if (restart)
      phase_q <= '0;
    else if (run && ref_pulse)
      phase_q <= at_last ? '0 : phase_q + 1'b1;
  end

  // A period holds at least two pulses, so ticks never fall on back-to-back cycles
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] alarm_q,
  input  logic             armed,
  input  logic             tick,
  input  logic             load,
  output logic             hit
);
  function automatic logic [CNT_W-1:0] stepped(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // Fires on the tick that moves the counter onto the alarm value
  assign hit = armed && tick && !load && (stepped(count_q) == alarm_q);
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] ev_set,
  input  logic                 wr,
  input  logic [NUM_SLOTS-1:0] ev_clr,
  input  logic [NUM_SLOTS-1:0] en_new,
  output logic [NUM_SLOTS-1:0] ev_q,
  output logic [NUM_SLOTS-1:0] en_q,
  output logic                 irq
);
  logic [NUM_SLOTS-1:0] clr_mask;
  assign clr_mask = wr ? ev_clr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      ev_q <= ev_set | (ev_q & ~clr_mask);
      if (wr) en_q <= en_new;
    end
  end

  assign irq = |(ev_q & en_q);

  AST_ALM0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[SLOT_ALM0]) |-> $past(en_q[SLOT_ALM0])); // R6
  AST_ALM1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[SLOT_ALM1]) |-> $past(en_q[SLOT_ALM1])); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[SLOT_TICK] |=> ev_q[SLOT_TICK]); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ev_clr[SLOT_ALM0] && !ev_set[SLOT_ALM0]) |=> !ev_q[SLOT_ALM0]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q == '0) |-> !irq); // R10
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int NUM_ALARMS = 2;
  localparam logic [7:0] ALARM_OFF [NUM_ALARMS] = '{OFF_ALARM0, OFF_ALARM1};
  localparam int ALARM_SLOT [NUM_ALARMS] = '{SLOT_ALM0, SLOT_ALM1};

  function automatic logic at_off(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // ---------------- bus decode ----------------
  logic wr_acc, rd_acc;
  logic wr_count, wr_status, wr_divide, wr_clksel, wr_scratch;
  assign wr_acc     = bus_sel && bus_wr;
  assign rd_acc     = bus_sel && !bus_wr;
  assign wr_count   = wr_acc && at_off(bus_addr, OFF_COUNT);
  assign wr_status  = wr_acc && at_off(bus_addr, OFF_STATUS);
  assign wr_divide  = wr_acc && at_off(bus_addr, OFF_DIVIDE);
  assign wr_clksel  = wr_acc && at_off(bus_addr, OFF_CLKSEL);
  assign wr_scratch = wr_acc && at_off(bus_addr, OFF_SCRTCH);

  // ---------------- configuration registers ----------------
  logic [DIV_W-1:0] divide_q;
  logic [1:0]       clksel_q;
  logic [CNT_W-1:0] scratch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divide_q  <= '0;
      clksel_q  <= '0;
      scratch_q <= '0;
    end else begin
      if (wr_divide)  divide_q  <= bus_wdata[DIV_W-1:0];
      if (wr_clksel)  clksel_q  <= bus_wdata[1:0];
      if (wr_scratch) scratch_q <= bus_wdata;
    end
  end

  // ---------------- tick generation ----------------
  logic tick;
  logic div_run;
  logic phase_restart;
  assign div_run       = (clksel_q == CLKSEL_REF);
  assign phase_restart = wr_count || wr_divide;

  rtc_prescaler #(.DIV_W(DIV_W)) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (div_run),
    .restart   (phase_restart),
    .ref_pulse (ref_pulse),
    .div_val   (divide_q),
    .tick      (tick)
  );

  // ---------------- counter ----------------
  logic [CNT_W-1:0] count_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (wr_count) count_q <= bus_wdata;
    else if (tick)     count_q <= count_q + 1'b1;
  end

  // ---------------- status ----------------
  logic [NUM_SLOTS-1:0] ev_set, ev_clr, en_new, ev_q, en_q;
  logic [NUM_ALARMS-1:0] alarm_hit;
  logic [CNT_W-1:0] alarm_q [NUM_ALARMS];

  always_comb begin
    ev_set            = '0;
    ev_set[SLOT_TICK] = tick && !wr_count;
    for (int i = 0; i < NUM_ALARMS; i++)
      ev_set[ALARM_SLOT[i]] = alarm_hit[i];
    ev_clr            = '0;
    ev_clr[SLOT_ALM0] = bus_wdata[ST_EV_ALM0];
    ev_clr[SLOT_TICK] = bus_wdata[ST_EV_TICK];
    ev_clr[SLOT_ALM1] = bus_wdata[ST_EV_ALM1];
    en_new            = '0;
    en_new[SLOT_ALM0] = bus_wdata[ST_EN_ALM0];
    en_new[SLOT_TICK] = bus_wdata[ST_EN_TICK];
    en_new[SLOT_ALM1] = bus_wdata[ST_EN_ALM1];
  end

  // ---------------- alarms ----------------
  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    logic wr_alarm;
    assign wr_alarm = wr_acc && at_off(bus_addr, ALARM_OFF[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)        alarm_q[g] <= '0;
      else if (wr_alarm) alarm_q[g] <= bus_wdata;
    end

    rtc_alarm_cmp #(.CNT_W(CNT_W)) u_cmp (
      .count_q (count_q),
      .alarm_q (alarm_q[g]),
      .armed   (en_q[ALARM_SLOT[g]]),
      .tick    (tick),
      .load    (wr_count),
      .hit     (alarm_hit[g])
    );

    AST_HIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit[g] |=> (count_q == alarm_q[g])); // R6
  end

  rtc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_set),
    .wr     (wr_status),
    .ev_clr (ev_clr),
    .en_new (en_new),
    .ev_q   (ev_q),
    .en_q   (en_q),
    .irq    (irq)
  );

  // ---------------- read path ----------------
  logic [CNT_W-1:0] status_word;
  logic [CNT_W-1:0] rd_word;

  always_comb begin
    status_word             = '0;
    status_word[ST_EV_ALM0] = ev_q[SLOT_ALM0];
    status_word[ST_EV_TICK] = ev_q[SLOT_TICK];
    status_word[ST_EN_ALM0] = en_q[SLOT_ALM0];
    status_word[ST_EN_TICK] = en_q[SLOT_TICK];
    status_word[ST_EV_ALM1] = ev_q[SLOT_ALM1];
    status_word[ST_EN_ALM1] = en_q[SLOT_ALM1];
  end

  always_comb begin
    rd_word = '0;
    if (at_off(bus_addr, OFF_COUNT))       rd_word = count_q;
    else if (at_off(bus_addr, OFF_ALARM0)) rd_word = alarm_q[0];
    else if (at_off(bus_addr, OFF_STATUS)) rd_word = status_word;
    else if (at_off(bus_addr, OFF_DIVIDE)) rd_word = CNT_W'(divide_q);
    else if (at_off(bus_addr, OFF_ALARM1)) rd_word = alarm_q[1];
    else if (at_off(bus_addr, OFF_CLKSEL)) rd_word = CNT_W'(clksel_q);
    else if (at_off(bus_addr, OFF_SCRTCH)) rd_word = scratch_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_word;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count) |=> (count_q == $past(count_q) + 1'b1)); // R4
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_q == $past(bus_wdata))); // R5
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count) |=> $stable(count_q)); // R3
  AST_SCRATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_scratch |=> $stable(scratch_q)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/test_rtc_timekeeper.sv
module test_rtc_timekeeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_pulse = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  rtc_timekeeper i_rtc_timekeeper (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Offsets from R2
  localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_ST = 8'h08, A_DIV = 8'h0C,
                         A_AL1 = 8'h18, A_CS = 8'h1C, A_SCR = 8'h40;

  // Vector table: divider, pulses, expected counter advance = pulses / (2*(div+1))
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{'{0, 2, 1}, '{0, 7, 3}, '{3, 16, 2},
                                   '{3, 15, 1}, '{9, 60, 3}, '{1, 4, 1}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic with_pulse = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ref_pulse = with_pulse;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ref_pulse = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_pulse = 1'b1;
    end
    @(negedge clk);
    ref_pulse = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    bus_read(A_CNT, rd); check("R1 counter", rd, 0);
    bus_read(A_AL0, rd); check("R1 alarm0", rd, 0);
    bus_read(A_ST,  rd); check("R1 status", rd, 0);
    bus_read(A_DIV, rd); check("R1 divider", rd, 0);
    bus_read(A_AL1, rd); check("R1 alarm1", rd, 0);
    bus_read(A_CS,  rd); check("R1 clksel", rd, 0);
    bus_read(A_SCR, rd); check("R1 scratch", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2: scratch and undecoded offset
    bus_write(A_SCR, 32'hA5C3_0F1E);
    pulses(3);
    bus_read(A_SCR, rd); check("R2 scratch", rd, 32'hA5C3_0F1E);
    bus_read(8'h20, rd); check("R2 undecoded", rd, 0);

    // R3: reserved clock select stops the divider
    pulses(10);
    bus_read(A_CNT, rd); check("R3 clksel 0 stopped", rd, 0);
    bus_write(A_CS, 32'h2);
    pulses(10);
    bus_read(A_CNT, rd); check("R3 clksel 2 stopped", rd, 0);
    bus_write(A_CS, 32'h3);
    bus_read(A_CS, rd); check("R2 clksel readback", rd, 3);

    // R3/R4: vector table
    for (int v = 0; v < NVEC; v++) begin
      bus_write(A_DIV, VEC[v][0]);
      bus_write(A_CNT, 1000 * v);
      pulses(VEC[v][1]);
      bus_read(A_CNT, rd);
      check($sformatf("R3 vector %0d", v), rd, 1000 * v + VEC[v][2]);
    end

    // R3: 16 ticks per 32768 pulses at divider 1023, with boundary
    bus_write(A_DIV, 1023);
    bus_write(A_CNT, 0);
    pulses(2047);
    bus_read(A_CNT, rd); check("R3 one pulse short", rd, 0);
    pulses(1);
    bus_read(A_CNT, rd); check("R3 first tick", rd, 1);
    pulses(32768 - 2048);
    bus_read(A_CNT, rd); check("R3 16 Hz", rd, 16);

    // R4: wrap
    bus_write(A_DIV, 0);
    bus_write(A_CNT, 32'hFFFF_FFFF);
    pulses(2);
    bus_read(A_CNT, rd); check("R4 wrap", rd, 0);

    // R5: write in the tick cycle wins, phase restarts
    bus_write(A_CNT, 50);
    pulses(1);
    bus_write(A_CNT, 100, 1'b1);
    pulses(1);
    bus_read(A_CNT, rd); check("R5 write beats tick", rd, 100);
    pulses(1);
    bus_read(A_CNT, rd); check("R5 count after load", rd, 101);

    // R11: rdata holds across ticks without a read
    pulses(4);
    check("R11 rdata held", bus_rdata, 101);

    // R6/R10: alarm0 armed
    bus_write(A_ST, 32'h13);
    bus_write(A_AL0, 5);
    bus_write(A_ST, 32'h04);
    bus_write(A_CNT, 3);
    pulses(2);
    bus_read(A_ST, rd); check("R6 no early alarm0", rd & 32'h55, 32'h04);
    check("R10 tick event masked", {31'b0, irq}, 0);
    pulses(2);
    bus_read(A_ST, rd); check("R6 alarm0 fires", rd & 32'h55, 32'h05);
    check("R10 irq on alarm0", {31'b0, irq}, 1);
    bus_write(A_ST, 32'h04);
    bus_read(A_ST, rd); check("R9 write 0 keeps event", rd & 32'h55, 32'h05);
    bus_write(A_ST, 32'h05);
    bus_read(A_ST, rd); check("R9 write 1 clears", rd & 32'h55, 32'h04);
    check("R10 irq drops", {31'b0, irq}, 0);

    // R6: disarmed alarm stays quiet
    bus_write(A_ST, 32'h00);
    bus_write(A_CNT, 4);
    pulses(2);
    bus_read(A_ST, rd); check("R6 disarmed", rd & 32'h55, 32'h00);

    // R7: alarm1
    bus_write(A_AL1, 9);
    bus_write(A_ST, 32'h40);
    bus_write(A_CNT, 8);
    pulses(2);
    bus_read(A_AL1, rd); check("R7 alarm1 readback", rd, 9);
    bus_read(A_ST, rd); check("R7 alarm1 fires", rd & 32'h55, 32'h50);
    check("R10 irq on alarm1", {31'b0, irq}, 1);
    bus_write(A_ST, 32'h50);
    bus_read(A_ST, rd); check("R9 clear alarm1", rd & 32'h55, 32'h40);

    // R8/R10: periodic tick event
    bus_write(A_ST, 32'h02);
    bus_read(A_ST, rd); check("R8 tick event cleared", rd & 32'h0A, 32'h00);
    pulses(2);
    bus_read(A_ST, rd); check("R8 tick event sets", rd & 32'h0A, 32'h02);
    check("R10 masked tick", {31'b0, irq}, 0);
    bus_write(A_ST, 32'h08);
    bus_read(A_ST, rd); check("R8 enable keeps event", rd & 32'h0A, 32'h0A);
    check("R10 irq on tick", {31'b0, irq}, 1);
    bus_write(A_ST, 32'h0A);
    bus_read(A_ST, rd); check("R9 tick cleared", rd & 32'h0A, 32'h08);
    check("R10 irq low", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule